// File: doc/BRIEF.md
# Accumulator Output Register with Sectioned Preload and Port Enables

This block holds the 35-bit result register of a multiply-accumulate datapath and controls the bidirectional ports that expose it. The register is split into three sections: a 3-bit extension on top, a 16-bit high word and a 16-bit low word. Each section has its own port, modelled as a separate input bus, output bus and output enable, so no internal tristate buffer is needed. The low port also carries the Y operand into the datapath, and a Y operand register in this block captures it.

On each product strobe, every section normally takes its slice of the next-accumulator value, which arrives from the arithmetic outside this block. When the load-from-port control is high, all ports are released. Each section whose active-low enable is also high then takes the value on its own port, and the other sections keep their contents. The port enables are decoded combinationally, so a change on the controls reaches the enable outputs in the same cycle.

Top module: `acc_port_ctl`

## Requirements
- R1: A synchronous reset clears all three section registers and the Y operand register to zero.
- R2: With `load_sel` low, a section's `*_pin_oe` is 1 while its `*_oe_n` is 0, in the same cycle and without a clock edge, and `*_pin_out` always shows that section's register.
- R3: With `load_sel` low, a section's `*_pin_oe` is 0 while its `*_oe_n` is 1.
- R4: With `load_sel` high, all three `*_pin_oe` are 0 whatever the `*_oe_n` values are.
- R5: With `load_sel` low, a clock edge with `strobe` high loads the extension section from `acc_next[34:32]`, the high section from `acc_next[31:16]` and the low section from `acc_next[15:0]`.
- R6: With `load_sel` high, a clock edge with `strobe` high loads every section whose `*_oe_n` is 1 from its own `*_pin_in`.
- R7: With `load_sel` high, a clock edge with `strobe` high leaves unchanged every section whose `*_oe_n` is 0. The arithmetic result is not applied to it.
- R8: A clock edge with `strobe` low changes no section register.
- R9: A clock edge with `y_load` high and `lo_oe_n` high copies `lo_pin_in` into `y_q`.
- R10: A clock edge with `y_load` high and `lo_oe_n` low leaves `y_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Product strobe; section registers update on edges where it is high |
| load_sel | input | 1 | High selects load-from-port and releases all ports |
| ext_oe_n | input | 1 | Active-low enable of the extension port |
| hi_oe_n | input | 1 | Active-low enable of the high port |
| lo_oe_n | input | 1 | Active-low enable of the low / Y port |
| acc_next | input | 35 | Next accumulator value from the arithmetic |
| y_load | input | 1 | Capture request for the Y operand |
| ext_pin_in | input | 3 | Value seen on the extension port |
| hi_pin_in | input | 16 | Value seen on the high port |
| lo_pin_in | input | 16 | Value seen on the low / Y port |
| ext_pin_out | output | 3 | Extension register contents |
| hi_pin_out | output | 16 | High register contents |
| lo_pin_out | output | 16 | Low register contents |
| ext_pin_oe | output | 1 | Drive enable of the extension port |
| hi_pin_oe | output | 1 | Drive enable of the high port |
| lo_pin_oe | output | 1 | Drive enable of the low / Y port |
| y_q | output | 16 | Captured Y operand |

## Verification
A section register that took the wrong source shows on its `*_pin_out` one cycle after the strobe edge. So the bench reads every section back after each load and compares each one on its own. Damage to a section that was meant to keep its value during a selective load stays hidden until the register is read back. The bench therefore reads the kept sections right after the load and again after normal operation resumes. A wrong enable decode appears at once, in the same cycle, so the enables are sampled before any edge for every control combination that matters.

// File: rtl/acc_port_pkg.sv
package acc_port_pkg;
  // one flag per section, top section first
  typedef struct packed {
    logic ext;
    logic hi;
    logic lo;
  } sect_flags_t;
endpackage

// File: rtl/port_decode.sv
module port_decode
  import acc_port_pkg::*;
(
  input  logic        load_sel,
  input  sect_flags_t oe_n,
  output sect_flags_t drive,
  output sect_flags_t take_pin
);
  // Ports drive only in normal mode with the enable asserted (low).
  // In load mode a released section (enable high) takes its port value.
  always_comb begin
    drive.ext    = !load_sel && !oe_n.ext;
    drive.hi     = !load_sel && !oe_n.hi;
    drive.lo     = !load_sel && !oe_n.lo;
    take_pin.ext = load_sel && oe_n.ext;
    take_pin.hi  = load_sel && oe_n.hi;
    take_pin.lo  = load_sel && oe_n.lo;
  end
endmodule

// File: rtl/acc_section.sv
module acc_section #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic         load_sel,
  input  logic         take_pin,
  input  logic [W-1:0] acc_slice,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (strobe) begin
      if (!load_sel) begin
        q <= acc_slice;
      end else if (take_pin) begin
        q <= pin_in;
      end
    end
  end

  // R5
  normal_load_chk: assert property (@(posedge clk) disable iff (rst)
    strobe && !load_sel |=> q == $past(acc_slice));
  // R6
  port_load_chk: assert property (@(posedge clk) disable iff (rst)
    strobe && load_sel && take_pin |=> q == $past(pin_in));
  // R7
  port_skip_chk: assert property (@(posedge clk) disable iff (rst)
    strobe && load_sel && !take_pin |=> $stable(q));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(q));
endmodule

// File: rtl/y_capture.sv
module y_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         y_load,
  input  logic         port_free,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] y_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      y_q <= '0;
    end else if (y_load && port_free) begin
      y_q <= pin_in;
    end
  end

  // R9
  y_take_chk: assert property (@(posedge clk) disable iff (rst)
    y_load && port_free |=> y_q == $past(pin_in));
  // R10
  y_block_chk: assert property (@(posedge clk) disable iff (rst)
    y_load && !port_free |=> $stable(y_q));
endmodule

// File: rtl/acc_port_ctl.sv
module acc_port_ctl
  import acc_port_pkg::*;
#(
  parameter int EXT_W = 3,
  parameter int HI_W  = 16,
  parameter int LO_W  = 16,
  localparam int ACC_W = EXT_W + HI_W + LO_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             load_sel,
  input  logic             ext_oe_n,
  input  logic             hi_oe_n,
  input  logic             lo_oe_n,
  input  logic [ACC_W-1:0] acc_next,
  input  logic             y_load,
  input  logic [EXT_W-1:0] ext_pin_in,
  input  logic [HI_W-1:0]  hi_pin_in,
  input  logic [LO_W-1:0]  lo_pin_in,
  output logic [EXT_W-1:0] ext_pin_out,
  output logic [HI_W-1:0]  hi_pin_out,
  output logic [LO_W-1:0]  lo_pin_out,
  output logic             ext_pin_oe,
  output logic             hi_pin_oe,
  output logic             lo_pin_oe,
  output logic [LO_W-1:0]  y_q
);
  localparam int HI_LSB  = LO_W;
  localparam int EXT_LSB = LO_W + HI_W;

  sect_flags_t oe_n_v, drive_v, take_v;

  assign oe_n_v = '{ext: ext_oe_n, hi: hi_oe_n, lo: lo_oe_n};

  port_decode u_dec (
    .load_sel (load_sel),
    .oe_n     (oe_n_v),
    .drive    (drive_v),
    .take_pin (take_v)
  );

  assign ext_pin_oe = drive_v.ext;
  assign hi_pin_oe  = drive_v.hi;
  assign lo_pin_oe  = drive_v.lo;

  acc_section #(.W(EXT_W)) u_ext (
    .clk (clk), .rst (rst), .strobe (strobe), .load_sel (load_sel),
    .take_pin (take_v.ext), .acc_slice (acc_next[EXT_LSB +: EXT_W]),
    .pin_in (ext_pin_in), .q (ext_pin_out)
  );

  acc_section #(.W(HI_W)) u_hi (
    .clk (clk), .rst (rst), .strobe (strobe), .load_sel (load_sel),
    .take_pin (take_v.hi), .acc_slice (acc_next[HI_LSB +: HI_W]),
    .pin_in (hi_pin_in), .q (hi_pin_out)
  );

  acc_section #(.W(LO_W)) u_lo (
    .clk (clk), .rst (rst), .strobe (strobe), .load_sel (load_sel),
    .take_pin (take_v.lo), .acc_slice (acc_next[LO_W-1:0]),
    .pin_in (lo_pin_in), .q (lo_pin_out)
  );

  y_capture #(.W(LO_W)) u_y (
    .clk (clk), .rst (rst), .y_load (y_load), .port_free (lo_oe_n),
    .pin_in (lo_pin_in), .y_q (y_q)
  );

  // R4
  all_released_chk: assert property (@(posedge clk) disable iff (rst)
    load_sel |-> !(ext_pin_oe || hi_pin_oe || lo_pin_oe));
  // R2
  hi_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !load_sel && !hi_oe_n |-> hi_pin_oe);
  // R3
  lo_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    lo_oe_n |-> !lo_pin_oe);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (ext_pin_out == '0 && hi_pin_out == '0 && lo_pin_out == '0 && y_q == '0));
endmodule

// File: tb/tb_acc_port_ctl.sv
module tb_acc_port_ctl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        strobe, load_sel, ext_oe_n, hi_oe_n, lo_oe_n, y_load;
  logic [34:0] acc_next;
  logic [2:0]  ext_pin_in, ext_pin_out;
  logic [15:0] hi_pin_in, lo_pin_in, hi_pin_out, lo_pin_out, y_q;
  logic        ext_pin_oe, hi_pin_oe, lo_pin_oe;

  int checks = 0;
  int errors = 0;

  // bench's own view of the registers
  logic [2:0]  m_ext;
  logic [15:0] m_hi, m_lo, m_y;

  always #(CLK_P/2) clk = ~clk;

  acc_port_ctl dut (
    .clk (clk), .rst (rst), .strobe (strobe), .load_sel (load_sel),
    .ext_oe_n (ext_oe_n), .hi_oe_n (hi_oe_n), .lo_oe_n (lo_oe_n),
    .acc_next (acc_next), .y_load (y_load),
    .ext_pin_in (ext_pin_in), .hi_pin_in (hi_pin_in), .lo_pin_in (lo_pin_in),
    .ext_pin_out (ext_pin_out), .hi_pin_out (hi_pin_out), .lo_pin_out (lo_pin_out),
    .ext_pin_oe (ext_pin_oe), .hi_pin_oe (hi_pin_oe), .lo_pin_oe (lo_pin_oe),
    .y_q (y_q)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    chk({req, " ext"}, 64'(ext_pin_out), 64'(m_ext));
    chk({req, " hi"},  64'(hi_pin_out),  64'(m_hi));
    chk({req, " lo"},  64'(lo_pin_out),  64'(m_lo));
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs;
    strobe = 0; load_sel = 0; y_load = 0;
    ext_oe_n = 1; hi_oe_n = 1; lo_oe_n = 1;
  endtask

  task automatic t_reset;
    rst = 1;
    idle_inputs();
    acc_next = 35'h7_FFFF_FFFF;
    ext_pin_in = 3'h7; hi_pin_in = 16'hFFFF; lo_pin_in = 16'hFFFF;
    tick(); tick();
    rst = 0;
    m_ext = '0; m_hi = '0; m_lo = '0; m_y = '0;
    chk_regs("R1");
    chk("R1 y", 64'(y_q), 64'(m_y));
  endtask

  task automatic t_enables;
    // normal mode, combinational decode checked before any edge
    load_sel = 0; ext_oe_n = 0; hi_oe_n = 0; lo_oe_n = 0;
    #1;
    chk("R2 oe all", 64'({ext_pin_oe, hi_pin_oe, lo_pin_oe}), 64'b111);
    ext_oe_n = 1; hi_oe_n = 0; lo_oe_n = 1;
    #1;
    chk("R3 oe mixed", 64'({ext_pin_oe, hi_pin_oe, lo_pin_oe}), 64'b010);
    ext_oe_n = 1; hi_oe_n = 1; lo_oe_n = 1;
    #1;
    chk("R3 oe none", 64'({ext_pin_oe, hi_pin_oe, lo_pin_oe}), 64'b000);
    load_sel = 1; ext_oe_n = 0; hi_oe_n = 0; lo_oe_n = 0;
    #1;
    chk("R4 oe low enables", 64'({ext_pin_oe, hi_pin_oe, lo_pin_oe}), 64'b000);
    ext_oe_n = 1; hi_oe_n = 1; lo_oe_n = 1;
    #1;
    chk("R4 oe high enables", 64'({ext_pin_oe, hi_pin_oe, lo_pin_oe}), 64'b000);
    idle_inputs();
    @(negedge clk);
  endtask

  task automatic t_normal_load(input logic [34:0] v);
    acc_next = v; strobe = 1; load_sel = 0;
    ext_oe_n = 0; hi_oe_n = 0; lo_oe_n = 0;
    tick();
    m_ext = v[34:32]; m_hi = v[31:16]; m_lo = v[15:0];
    chk_regs("R5");
    chk("R2 pins shown", 64'({ext_pin_oe, hi_pin_oe, lo_pin_oe}), 64'b111);
    idle_inputs();
  endtask

  task automatic t_port_load(input logic en_ext, input logic en_hi, input logic en_lo,
                             input logic [2:0] pe, input logic [15:0] ph, input logic [15:0] pl);
    acc_next = 35'h2_1234_5678;
    ext_pin_in = pe; hi_pin_in = ph; lo_pin_in = pl;
    strobe = 1; load_sel = 1;
    ext_oe_n = en_ext; hi_oe_n = en_hi; lo_oe_n = en_lo;
    tick();
    if (en_ext) m_ext = pe;
    if (en_hi)  m_hi  = ph;
    if (en_lo)  m_lo  = pl;
    chk_regs((en_ext && en_hi && en_lo) ? "R6" : "R6/R7");
    idle_inputs();
    // kept sections read back once normal mode resumes, no strobe
    tick();
    chk_regs("R7 readback");
  endtask

  task automatic t_no_strobe;
    acc_next = 35'h1_0F0F_F0F0;
    ext_pin_in = 3'h1; hi_pin_in = 16'h1111; lo_pin_in = 16'h2222;
    strobe = 0; load_sel = 0;
    tick();
    chk_regs("R8 normal");
    load_sel = 1; ext_oe_n = 1; hi_oe_n = 1; lo_oe_n = 1;
    tick();
    chk_regs("R8 load mode");
    idle_inputs();
  endtask

  task automatic t_y_capture;
    lo_pin_in = 16'hBEEF; lo_oe_n = 1; y_load = 1;
    tick();
    m_y = 16'hBEEF;
    chk("R9 y", 64'(y_q), 64'(m_y));
    lo_pin_in = 16'h0BAD; lo_oe_n = 0; y_load = 1;
    tick();
    chk("R10 y", 64'(y_q), 64'(m_y));
    lo_pin_in = 16'h4321; lo_oe_n = 1; y_load = 0;
    tick();
    chk("R9 no request", 64'(y_q), 64'(m_y));
    idle_inputs();
  endtask

  initial begin
    t_reset();
    t_enables();
    t_normal_load(35'h5_A5A5_3C3C);
    t_normal_load(35'h2_0001_8000);
    t_port_load(1, 1, 1, 3'h6, 16'hC0DE, 16'hFACE);
    t_normal_load(35'h7_1357_2468);
    t_port_load(1, 0, 0, 3'h1, 16'hAAAA, 16'h5555);
    t_port_load(0, 1, 0, 3'h4, 16'h9999, 16'h6666);
    t_port_load(0, 0, 1, 3'h2, 16'h7777, 16'h8888);
    t_no_strobe();
    t_y_capture();
    t_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 5000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule